// File: doc/BRIEF.md
# Asynchronous Memory Bank Enable Decoder

This block is the register front end of an external asynchronous memory port. A small register bus reaches three registers: a 16-bit global control register and two 32-bit bank timing registers. The timing registers are only stored and read back. The global control register sets how many of four equal, adjacent memory banks are switched on.

From that count, the block maps an external memory-space address to a one-hot bank select. If the address has no enabled bank, it raises a decode-miss output instead. The select logic is combinational and always uses the register's current value, so a control write takes effect on the next cycle.

Each register access finishes in one clock. Read data and an error pulse appear in the cycle after the strobe.

Top module: `asyncmem_bank_ctrl`

## Requirements
- R1: After reset, the global control register reads 0x00F2 and both bank timing registers read 0xFFC2FFC2.
- R2: An access whose size code (`regSize`, in bytes) is neither 2 nor 4 reports an error at any offset, mapped or not, and writes nothing.
- R3: The global control register sits at offset 0x0 and takes only 2-byte accesses. A 2-byte write stores `regWdata[15:0]`, and a read returns it zero-extended. A 4-byte access to it is an error and leaves it unchanged.
- R4: The bank timing registers sit at offsets 0x4 and 0x8 and take only 4-byte accesses, which store and return all 32 bits. A 2-byte access to them is an error and leaves them unchanged.
- R5: Every other offset in the 16-byte window is unmapped. A write there is dropped and raises an error, and a read there raises an error.
- R6: `regErr` and `regRdata` are registered and valid in the cycle after the strobe. `regErr` is a one-cycle pulse, and `regRdata` is zero for an erroneous read and whenever no read is under way.
- R7: The enabled-bank count is bits [3:1] of the global control register, and any value above 4 counts as 4.
- R8: Bank i covers `BANK_BASE + i*2^BANK_SIZE_LOG2` up to the next bank's start minus one. When i is below the enabled count, an address in that range drives `bankSel[i]` alone and clears `decodeMiss`.
- R9: An address below `BANK_BASE`, at or above the end of bank 3, or inside a disabled bank drives `bankSel` to zero and raises `decodeMiss`.
- R10: A global control write strobed in cycle N changes the decode from cycle N+1 on, and cycle N still decodes with the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Byte offset inside the register window |
| regWdata | input | 32 | Write data |
| regWrite | input | 1 | Write strobe, one cycle per access |
| regRead | input | 1 | Read strobe, one cycle per access; ignored when regWrite is high |
| regSize | input | 3 | Access size in bytes |
| regRdata | output | 32 | Read data, registered |
| regErr | output | 1 | Access error pulse, registered |
| memAddr | input | ADDR_W | External memory-space address to decode |
| bankSel | output | 4 | One-hot bank select |
| decodeMiss | output | 1 | No enabled bank holds memAddr |

## Verification
The bench uses a count field of 7 to test the clamp. A design that did not clamp the field would leave bank 3 dark or accept an index past the last bank.

It checks both edges of every bank and the first address past bank 3. An off-by-one in the range compare shows up there as a select on the wrong bank or a missing miss.

It sends 4-byte accesses to the 16-bit register and 2-byte accesses to the wide ones, then reads each register back. A design that checked only the offset would corrupt the register and report no error. It also sends odd sizes to unmapped offsets, where a design that skipped the size check would still write nothing but might report nothing either.

During a control write, it samples the decode both before and after the clock edge. This catches a decoder that lags by a cycle or that bypasses the incoming write data straight to the decode.

// File: rtl/amc_pkg.sv
`timescale 1ns/1ps
package amc_pkg;
  localparam logic [3:0] OFS_GCTL  = 4'h0;
  localparam logic [3:0] OFS_BANK0 = 4'h4;
  localparam logic [3:0] OFS_BANK1 = 4'h8;

  localparam logic [15:0] GCTL_RST = 16'h00F2;
  localparam logic [31:0] BANK_RST = 32'hFFC2_FFC2;

  localparam logic [2:0] SZ_HALF = 3'd2;
  localparam logic [2:0] SZ_WORD = 3'd4;

  localparam int NUM_BANKS = 4;
  localparam int CNT_W     = 3;

  typedef struct packed {
    logic       wrGctl;
    logic       wrBank0;
    logic       wrBank1;
    logic       rdEn;
    logic [1:0] rdSel;
    logic       accErr;
  } amcStrobe_t;
endpackage

// File: rtl/amc_ctrl.sv
`timescale 1ns/1ps
module amc_ctrl
  import amc_pkg::*;
(
  input  logic [3:0]  regAddr,
  input  logic        regWrite,
  input  logic        regRead,
  input  logic [2:0]  regSize,
  output amcStrobe_t  strb
);
  logic access;
  logic sizeOk;
  logic regOk;
  logic err;

  assign access = regWrite | regRead;

  // Size legality is decided before the offset is looked at.
  assign sizeOk = (regSize == SZ_HALF) || (regSize == SZ_WORD);

  always_comb begin
    case (regAddr)
      OFS_GCTL:             regOk = (regSize == SZ_HALF);
      OFS_BANK0, OFS_BANK1: regOk = (regSize == SZ_WORD);
      default:              regOk = 1'b0;
    endcase
  end

  assign err = access && !(sizeOk && regOk);

  always_comb begin
    strb         = '0;
    strb.accErr  = err;
    strb.rdSel   = regAddr[3:2];
    strb.wrGctl  = regWrite && !err && (regAddr == OFS_GCTL);
    strb.wrBank0 = regWrite && !err && (regAddr == OFS_BANK0);
    strb.wrBank1 = regWrite && !err && (regAddr == OFS_BANK1);
    strb.rdEn    = regRead && !regWrite && !err;
  end
endmodule

// File: rtl/amc_datapath.sv
`timescale 1ns/1ps
module amc_datapath
  import amc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  amcStrobe_t        strb,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              regErr,
  output logic [15:0]       gctlQ,
  output logic [CNT_W-1:0]  enCount
);
  logic [31:0] bank0Q;
  logic [31:0] bank1Q;
  logic [31:0] rdMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gctlQ  <= GCTL_RST;
      bank0Q <= BANK_RST;
      bank1Q <= BANK_RST;
    end else begin
      if (strb.wrGctl)  gctlQ  <= regWdata[15:0];
      if (strb.wrBank0) bank0Q <= regWdata;
      if (strb.wrBank1) bank1Q <= regWdata;
    end
  end

  always_comb begin
    case (strb.rdSel)
      2'd0:    rdMux = {16'h0000, gctlQ};
      2'd1:    rdMux = bank0Q;
      2'd2:    rdMux = bank1Q;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdata <= '0;
      regErr   <= 1'b0;
    end else begin
      regRdata <= strb.rdEn ? rdMux : '0;
      regErr   <= strb.accErr;
    end
  end

  // Count field clamps at the number of banks.
  assign enCount = (gctlQ[3:1] > CNT_W'(NUM_BANKS)) ? CNT_W'(NUM_BANKS) : gctlQ[3:1];
endmodule

// File: rtl/amc_bank_map.sv
`timescale 1ns/1ps
module amc_bank_map
  import amc_pkg::*;
#(
  parameter int              ADDR_W         = 32,
  parameter logic [ADDR_W-1:0] BANK_BASE    = 32'h2000_0000,
  parameter int              BANK_SIZE_LOG2 = 20
) (
  input  logic [ADDR_W-1:0]    memAddr,
  input  logic [CNT_W-1:0]     enCount,
  output logic [NUM_BANKS-1:0] bankSel,
  output logic                 decodeMiss
);
  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] bankNum;
  logic              aboveBase;

  assign aboveBase = (memAddr >= BANK_BASE);
  assign offs      = memAddr - BANK_BASE;
  assign bankNum   = offs >> BANK_SIZE_LOG2;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign bankSel[i] = aboveBase && (bankNum == ADDR_W'(i)) && (CNT_W'(i) < enCount);
  end

  assign decodeMiss = ~|bankSel;
endmodule

// File: rtl/asyncmem_bank_ctrl.sv
`timescale 1ns/1ps
module asyncmem_bank_ctrl
  import amc_pkg::*;
#(
  parameter int                ADDR_W         = 32,
  parameter logic [ADDR_W-1:0] BANK_BASE      = 32'h2000_0000,
  parameter int                BANK_SIZE_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWdata,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [2:0]        regSize,
  output logic [31:0]       regRdata,
  output logic              regErr,
  input  logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        bankSel,
  output logic              decodeMiss
);
  amcStrobe_t       strb;
  logic [15:0]      gctlQ;
  logic [CNT_W-1:0] enCount;

  amc_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrite(regWrite),
    .regRead (regRead),
    .regSize (regSize),
    .strb    (strb)
  );

  amc_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .regErr  (regErr),
    .gctlQ   (gctlQ),
    .enCount (enCount)
  );

  amc_bank_map #(
    .ADDR_W        (ADDR_W),
    .BANK_BASE     (BANK_BASE),
    .BANK_SIZE_LOG2(BANK_SIZE_LOG2)
  ) u_map (
    .memAddr   (memAddr),
    .enCount   (enCount),
    .bankSel   (bankSel),
    .decodeMiss(decodeMiss)
  );
endmodule

// File: rtl/amc_checker.sv
`timescale 1ns/1ps
module amc_checker (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  regAddr,
  input logic        regWrite,
  input logic        regRead,
  input logic [2:0]  regSize,
  input logic [31:0] regRdata,
  input logic        regErr,
  input logic [3:0]  bankSel,
  input logic        decodeMiss,
  input logic [15:0] gctlQ
);
  logic access;
  logic mapped;
  assign access = regWrite | regRead;
  assign mapped = (regAddr == 4'h0) || (regAddr == 4'h4) || (regAddr == 4'h8);

  assert_size_err_R2: assert property (@(posedge clk) disable iff (!rstN)
    (access && (regSize != 3'd2) && (regSize != 3'd4)) |=> regErr);

  assert_gctl_wide_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && (regAddr == 4'h0) && (regSize == 3'd4)) |=> (regErr && $stable(gctlQ)));

  assert_bank_word_ok_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && (regAddr == 4'h4) && (regSize == 3'd4)) |=> !regErr);

  assert_unmapped_R5: assert property (@(posedge clk) disable iff (!rstN)
    (access && !mapped) |=> regErr);

  assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    regErr |-> (regRdata == 32'h0));

  assert_clamp_R7: assert property (@(posedge clk) disable iff (!rstN)
    bankSel[3] |-> (gctlQ[3:1] >= 3'd4));

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankSel));

  assert_miss_R9: assert property (@(posedge clk) disable iff (!rstN)
    decodeMiss != (|bankSel));
endmodule

bind asyncmem_bank_ctrl amc_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrite  (regWrite),
  .regRead   (regRead),
  .regSize   (regSize),
  .regRdata  (regRdata),
  .regErr    (regErr),
  .bankSel   (bankSel),
  .decodeMiss(decodeMiss),
  .gctlQ     (gctlQ)
);

// File: tb/test_asyncmem_bank_ctrl.sv
`timescale 1ns/1ps
module test_asyncmem_bank_ctrl;
  localparam logic [31:0] BASE = 32'h2000_0000;
  localparam logic [31:0] BSZ  = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        regWrite = 1'b0;
  logic        regRead = 1'b0;
  logic [2:0]  regSize = 3'd2;
  logic [31:0] regRdata;
  logic        regErr;
  logic [31:0] memAddr = BASE;
  logic [3:0]  bankSel;
  logic        decodeMiss;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  logic accPrev = 1'b0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } expItem_t;
  expItem_t sbQ[$];

  always #4 clk = ~clk;

  asyncmem_bank_ctrl i_asyncmem_bank_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWrite(regWrite), .regRead(regRead), .regSize(regSize),
    .regRdata(regRdata), .regErr(regErr), .memAddr(memAddr),
    .bankSel(bankSel), .decodeMiss(decodeMiss)
  );

  always @(posedge clk) accPrev <= regWrite | regRead;

  // Monitor: compare the registered response one cycle after each strobe.
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (accPrev) begin
        if (sbQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL R6: response with no expected item, data=%h err=%b", regRdata, regErr);
        end else begin
          expItem_t e;
          e = sbQ.pop_front();
          checks++;
          if (regRdata !== e.data || regErr !== e.err) begin
            fails++;
            $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                     e.tag, regRdata, regErr, e.data, e.err);
          end
        end
      end else begin
        checks++;
        if (regErr !== 1'b0 || regRdata !== 32'h0) begin
          fails++;
          $display("FAIL R6: idle cycle rdata=%h err=%b expected rdata=0 err=0", regRdata, regErr);
        end
      end
    end
  end

  task automatic pushExp(input logic [31:0] d, input logic e, input string tag);
    expItem_t it;
    it.data = d; it.err = e; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic access(input bit isWr, input logic [3:0] a, input logic [2:0] sz,
                        input logic [31:0] wd, input logic [31:0] expD,
                        input logic expE, input string tag);
    @(negedge clk);
    regAddr = a; regSize = sz; regWdata = wd;
    regWrite = isWr; regRead = !isWr;
    pushExp(isWr ? 32'h0 : expD, expE, tag);
    @(negedge clk);
    regWrite = 1'b0; regRead = 1'b0;
  endtask

  task automatic checkDec(input logic [31:0] a, input logic [3:0] expSel, input string tag);
    memAddr = a;
    #1;
    checks++;
    if (bankSel !== expSel || decodeMiss !== (expSel == 4'h0)) begin
      fails++;
      $display("FAIL %s: addr=%h bankSel=%b miss=%b expected bankSel=%b miss=%b",
               tag, a, bankSel, decodeMiss, expSel, (expSel == 4'h0));
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values
    access(0, 4'h0, 3'd2, 0, 32'h0000_00F2, 0, "R1 gctl reset");
    access(0, 4'h4, 3'd4, 0, 32'hFFC2_FFC2, 0, "R1 bank0 reset");
    access(0, 4'h8, 3'd4, 0, 32'hFFC2_FFC2, 0, "R1 bank1 reset");

    // R7/R8/R9 at reset count 1
    @(negedge clk);
    checkDec(BASE,              4'b0001, "R8 bank0 first byte");
    checkDec(BASE + BSZ - 1,    4'b0001, "R8 bank0 last byte");
    checkDec(BASE + BSZ,        4'b0000, "R9 bank1 disabled");
    checkDec(BASE - 1,          4'b0000, "R9 below base");

    // R4: wide registers
    access(1, 4'h4, 3'd4, 32'h1234_5678, 0, 0, "R4 bank0 word write");
    access(0, 4'h4, 3'd4, 0, 32'h1234_5678, 0, "R4 bank0 readback");
    access(1, 4'h8, 3'd2, 32'h0000_1111, 0, 1, "R4 bank1 half write err");
    access(0, 4'h8, 3'd4, 0, 32'hFFC2_FFC2, 0, "R4 bank1 unchanged");
    access(0, 4'h4, 3'd2, 0, 32'h0, 1, "R4 bank0 half read err");

    // R3: global control width
    access(1, 4'h0, 3'd4, 32'h0000_0008, 0, 1, "R3 gctl word write err");
    access(0, 4'h0, 3'd2, 0, 32'h0000_00F2, 0, "R3 gctl unchanged");
    access(0, 4'h0, 3'd4, 0, 32'h0, 1, "R3 gctl word read err");
    access(1, 4'h0, 3'd2, 32'hABCD_0004, 0, 0, "R3 gctl half write");
    access(0, 4'h0, 3'd2, 0, 32'h0000_0004, 0, "R3 gctl upper dropped");
    checkDec(BASE + BSZ,        4'b0010, "R7 count 2 bank1");
    checkDec(BASE + 2*BSZ,      4'b0000, "R9 count 2 bank2 off");

    // R2: bad sizes, mapped and unmapped
    access(1, 4'h4, 3'd1, 32'hDEAD_BEEF, 0, 1, "R2 byte write mapped");
    access(1, 4'h4, 3'd3, 32'hDEAD_BEEF, 0, 1, "R2 size3 write mapped");
    access(0, 4'h4, 3'd4, 0, 32'h1234_5678, 0, "R2 bank0 untouched");
    access(0, 4'hC, 3'd1, 0, 32'h0, 1, "R2 byte read unmapped");
    access(1, 4'h0, 3'd1, 32'h0000_0008, 0, 1, "R2 byte write gctl");
    access(0, 4'h0, 3'd2, 0, 32'h0000_0004, 0, "R2 gctl untouched");

    // R5: unmapped offsets
    access(1, 4'hC, 3'd4, 32'h5555_5555, 0, 1, "R5 write 0xC");
    access(0, 4'hC, 3'd4, 0, 32'h0, 1, "R5 read 0xC");
    access(0, 4'h2, 3'd2, 0, 32'h0, 1, "R5 read 0x2");
    access(1, 4'h6, 3'd2, 32'h0000_000E, 0, 1, "R5 write 0x6");
    access(0, 4'h0, 3'd2, 0, 32'h0000_0004, 0, "R5 gctl untouched");

    // R10: live remap, count 2 -> 4
    @(negedge clk);
    regAddr = 4'h0; regSize = 3'd2; regWdata = 32'h0000_0008;
    regWrite = 1'b1;
    pushExp(32'h0, 0, "R10 gctl write");
    checkDec(BASE + 3*BSZ, 4'b0000, "R10 old count in cycle N");
    @(negedge clk);
    regWrite = 1'b0;
    checkDec(BASE + 3*BSZ, 4'b1000, "R10 new count in cycle N+1");
    checkDec(BASE + 4*BSZ - 1, 4'b1000, "R8 bank3 last byte");
    checkDec(BASE + 4*BSZ, 4'b0000, "R9 past bank3");

    // R7: clamp
    access(1, 4'h0, 3'd2, 32'h0000_000E, 0, 0, "R7 gctl count 7");
    checkDec(BASE + 3*BSZ, 4'b1000, "R7 clamp 7 to 4");
    checkDec(BASE + 4*BSZ, 4'b0000, "R7 no fifth bank");
    access(1, 4'h0, 3'd2, 32'h0000_0006, 0, 0, "R7 gctl count 3");
    checkDec(BASE + 2*BSZ, 4'b0100, "R7 count 3 bank2");
    checkDec(BASE + 3*BSZ, 4'b0000, "R7 count 3 bank3 off");
    access(1, 4'h0, 3'd2, 32'h0000_0001, 0, 0, "R7 gctl count 0");
    checkDec(BASE, 4'b0000, "R7 count 0 all off");

    repeat (3) @(negedge clk);
    if (sbQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL R6: %0d responses missing, expected 0", sbQ.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule